// File: doc/BRIEF.md
# Flash Self-Programming Control Register

This block is the 8-bit control and status register that a CPU uses to drive self-programming of its own program flash. Software writes the register with the enable bit and at most one command bit set. That write arms the block for a short, fixed number of clocks. If the CPU executes a store-to-program-memory instruction inside that window, the block turns the armed command into a single-cycle strobe toward the flash controller: page erase, page write, page-buffer load, lock-bit set, or read-while-write section re-enable. If the window closes with no such instruction, the armed bits drop by themselves.

A signature-read arming works differently. For a few cycles it redirects program-memory loads to the signature row, and it blocks any store during its window. An erase or write sets a sticky busy flag for the read-while-write section. That flag clears only through a re-enable command or a page-buffer load. The enable bit stays set while an erase or write runs. It drops when the flash controller reports completion, and from then on a level-type ready interrupt is raised, provided software and the global interrupt flag both allow it. The block also turns a boot-reset fuse input into the reset vector.

Top module: `flash_selfprog_ctrl`

## Requirements
- R1: The register reads as bit 7 interrupt enable, bit 6 section busy, bit 5 signature read, bit 4 section re-enable, bit 3 lock set, bit 2 page write, bit 1 page erase, bit 0 enable. All bits are 0 after reset, and bit 6 cannot be written by software.
- R2: `ready_irq_o` is high exactly while bit 7 is 1, `global_ie_i` is 1 and bit 0 reads 0.
- R3: A store accepted with page erase or page write armed pulses `erase_o` or `write_o` in the same cycle and sets the busy bit, which `rww_busy_o` also shows, from the next cycle on.
- R4: A store accepted with only bit 4 armed pulses `rww_reen_o` and clears the busy bit.
- R5: A store accepted with no command bit armed (page-buffer load) pulses `bufload_o` and clears the busy bit.
- R6: After an arming write at clock edge k, a store is accepted only at edges k+1 to k+4. If no store is accepted by edge k+4, bit 0 and the armed command bits read 0 afterwards.
- R7: After an arming write of bits 5 and 0 at edge k, a load sampled at edges k+1 to k+3 raises `sig_sel_o`, and a load at any later edge does not. A store during this arming produces no command strobe and changes no bit.
- R8: `reset_vec_o` equals the boot-loader start address when `boot_fuse_i` is 0, and 0x0000 when it is 1.
- R9: A write with bit 0 set and two or more of bits 5, 3, 2, 1 set leaves the register unchanged and arms nothing.
- R10: During an erase or write, bit 0 and the command bit stay 1 until `flash_done_i`. After that they read 0 and the busy bit stays 1.
- R11: A write while armed or while an operation runs changes only bit 7.
- R12: A lock-bit arming followed by a store pulses `lock_o` and returns bit 0 and bit 3 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| spm_exec_i | input | 1 | Store-to-program-memory instruction executes |
| lpm_exec_i | input | 1 | Load-from-program-memory instruction executes |
| global_ie_i | input | 1 | Global interrupt flag |
| flash_done_i | input | 1 | Flash controller completed erase or write |
| boot_fuse_i | input | 1 | Boot-reset fuse, 0 = programmed |
| erase_o | output | 1 | Page erase strobe |
| write_o | output | 1 | Page write strobe |
| bufload_o | output | 1 | Page-buffer load strobe |
| lock_o | output | 1 | Lock-bit set strobe |
| rww_reen_o | output | 1 | Section re-enable strobe |
| sig_sel_o | output | 1 | Current load returns a signature-row byte |
| rww_busy_o | output | 1 | Section busy, section reads must be blocked |
| ready_irq_o | output | 1 | Ready interrupt request, level type |
| reset_vec_o | output | AW | Reset vector address |

## Verification
A wrong arming counter shows at the strobe outputs on the first store placed one edge inside or outside the window. Stale armed bits show in the read data one cycle after the window ends. A busy flag that is lost or stuck shows on `rww_busy_o` in the cycle after the store that should have changed it. A wrong enable-bit lifetime shows at once on `ready_irq_o`, because the interrupt follows that bit with no register in between. Sweeping the store and load positions across every edge of both windows places each of these faults within one clock of its cause.

// File: rtl/spm_ctrl_pkg.sv
package spm_ctrl_pkg;
   localparam int B_IE    = 7;
   localparam int B_BUSY  = 6;
   localparam int B_SIG   = 5;
   localparam int B_RWWRE = 4;
   localparam int B_LOCK  = 3;
   localparam int B_PGWR  = 2;
   localparam int B_PGERS = 1;
   localparam int B_EN    = 0;

   typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_OPER} spm_state_e;
   typedef enum logic [2:0] {K_LOAD, K_ERASE, K_WRITE, K_LOCK, K_SIG, K_RWWRE, K_BAD} spm_kind_e;
endpackage

// File: rtl/spm_cmd_classify.sv
module spm_cmd_classify
   import spm_ctrl_pkg::*;
(
   input  logic       sig_i,
   input  logic       rwwre_i,
   input  logic       lock_i,
   input  logic       pgwr_i,
   input  logic       pgers_i,
   output spm_kind_e  kind_o
);
   logic [2:0] n_cmd;
   assign n_cmd = 3'(sig_i) + 3'(lock_i) + 3'(pgwr_i) + 3'(pgers_i);

   always_comb begin
      if (n_cmd > 3'd1)  kind_o = K_BAD;
      else if (pgers_i)  kind_o = K_ERASE;
      else if (pgwr_i)   kind_o = K_WRITE;
      else if (lock_i)   kind_o = K_LOCK;
      else if (sig_i)    kind_o = K_SIG;
      else if (rwwre_i)  kind_o = K_RWWRE;
      else               kind_o = K_LOAD;
   end
endmodule

// File: rtl/spm_arm_timer.sv
module spm_arm_timer #(
   parameter int WIN = 4,
   localparam int CW = $clog2(WIN + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic          run_i,
   output logic [CW-1:0] cnt_o,
   output logic          last_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          cnt_o <= '0;
      else if (load_i)                     cnt_o <= CW'(WIN);
      else if (run_i && cnt_o != '0)       cnt_o <= cnt_o - 1'b1;
   end
   assign last_o = (cnt_o == CW'(1));

   AST_TIMER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> cnt_o == CW'(WIN)); // R6
endmodule

// File: rtl/flash_selfprog_ctrl.sv
module flash_selfprog_ctrl
   import spm_ctrl_pkg::*;
#(
   parameter int AW              = 16,
   parameter int BOOT_ADDR       = 'h4C00,
   parameter int SPM_WIN         = 4,
   parameter int LPM_WIN         = 3,
   parameter bit LOCK_WAITS_DONE = 1'b0,
   localparam int CW = $clog2(SPM_WIN + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr_i,
   input  logic [7:0]    reg_wdata_i,
   output logic [7:0]    reg_rdata_o,
   input  logic          spm_exec_i,
   input  logic          lpm_exec_i,
   input  logic          global_ie_i,
   input  logic          flash_done_i,
   input  logic          boot_fuse_i,
   output logic          erase_o,
   output logic          write_o,
   output logic          bufload_o,
   output logic          lock_o,
   output logic          rww_reen_o,
   output logic          sig_sel_o,
   output logic          rww_busy_o,
   output logic          ready_irq_o,
   output logic [AW-1:0] reset_vec_o
);
   // elaboration-time parameter checks
   if (LPM_WIN < 1 || LPM_WIN > SPM_WIN) begin : g_bad_win
      $error("LPM_WIN must lie in 1..SPM_WIN");
   end
   if (AW < 31 && BOOT_ADDR >= (1 << AW)) begin : g_bad_addr
      $error("BOOT_ADDR does not fit in AW bits");
   end

   spm_state_e state_q;
   spm_kind_e  kind_q, kind_w;
   logic ie_q, busy_q, sig_q, rwwre_q, lock_q, pgwr_q, pgers_q, en_q;
   logic [CW-1:0] cnt;
   logic last, arm_ok, wr_bad, accept, start_op, go_idle, lock_oper;

   spm_cmd_classify u_cls (
      .sig_i   (reg_wdata_i[B_SIG]),
      .rwwre_i (reg_wdata_i[B_RWWRE]),
      .lock_i  (reg_wdata_i[B_LOCK]),
      .pgwr_i  (reg_wdata_i[B_PGWR]),
      .pgers_i (reg_wdata_i[B_PGERS]),
      .kind_o  (kind_w)
   );

   spm_arm_timer #(.WIN(SPM_WIN)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (arm_ok),
      .run_i  (state_q == ST_ARMED),
      .cnt_o  (cnt),
      .last_o (last)
   );

   // variant: lock-bit set either completes at once or waits for the flash controller
   if (LOCK_WAITS_DONE) begin : g_lock_wait
      assign lock_oper = 1'b1;
   end else begin : g_lock_fast
      assign lock_oper = 1'b0;
   end

   assign arm_ok   = (state_q == ST_IDLE) && reg_wr_i && reg_wdata_i[B_EN] && (kind_w != K_BAD);
   assign wr_bad   = (state_q == ST_IDLE) && reg_wr_i && reg_wdata_i[B_EN] && (kind_w == K_BAD);
   assign accept   = (state_q == ST_ARMED) && spm_exec_i && (kind_q != K_SIG);
   assign start_op = accept && ((kind_q == K_ERASE) || (kind_q == K_WRITE) ||
                                ((kind_q == K_LOCK) && lock_oper));
   assign go_idle  = ((state_q == ST_ARMED) && ((accept && !start_op) || (!accept && last))) ||
                     ((state_q == ST_OPER) && flash_done_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         kind_q  <= K_LOAD;
         ie_q    <= 1'b0;
         busy_q  <= 1'b0;
         sig_q   <= 1'b0;
         rwwre_q <= 1'b0;
         lock_q  <= 1'b0;
         pgwr_q  <= 1'b0;
         pgers_q <= 1'b0;
         en_q    <= 1'b0;
      end else begin
         if (reg_wr_i && !wr_bad) ie_q <= reg_wdata_i[B_IE];
         if (arm_ok) begin
            state_q <= ST_ARMED;
            kind_q  <= kind_w;
            sig_q   <= reg_wdata_i[B_SIG];
            rwwre_q <= reg_wdata_i[B_RWWRE];
            lock_q  <= reg_wdata_i[B_LOCK];
            pgwr_q  <= reg_wdata_i[B_PGWR];
            pgers_q <= reg_wdata_i[B_PGERS];
            en_q    <= 1'b1;
         end else if (start_op) begin
            state_q <= ST_OPER;
         end else if (go_idle) begin
            state_q <= ST_IDLE;
            sig_q   <= 1'b0;
            rwwre_q <= 1'b0;
            lock_q  <= 1'b0;
            pgwr_q  <= 1'b0;
            pgers_q <= 1'b0;
            en_q    <= 1'b0;
         end
         if (start_op && (kind_q != K_LOCK))
            busy_q <= 1'b1;
         else if (accept && ((kind_q == K_RWWRE) || (kind_q == K_LOAD)))
            busy_q <= 1'b0;
      end
   end

   assign erase_o     = accept && (kind_q == K_ERASE);
   assign write_o     = accept && (kind_q == K_WRITE);
   assign lock_o      = accept && (kind_q == K_LOCK);
   assign rww_reen_o  = accept && (kind_q == K_RWWRE);
   assign bufload_o   = accept && (kind_q == K_LOAD);
   assign sig_sel_o   = (state_q == ST_ARMED) && (kind_q == K_SIG) && lpm_exec_i &&
                        (cnt > CW'(SPM_WIN - LPM_WIN));
   assign rww_busy_o  = busy_q;
   assign reg_rdata_o = {ie_q, busy_q, sig_q, rwwre_q, lock_q, pgwr_q, pgers_q, en_q};
   assign ready_irq_o = ie_q && global_ie_i && !en_q;
   assign reset_vec_o = boot_fuse_i ? '0 : AW'(BOOT_ADDR);

   AST_RO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_IDLE) && reg_wr_i && !reg_wdata_i[B_EN] && reg_wdata_i[B_BUSY] && !rww_busy_o)
      |=> !rww_busy_o); // R1
   AST_IRQ_NEEDS_IDLE_EN: assert property (@(posedge clk) disable iff (!rst_n)
      ready_irq_o |-> !reg_rdata_o[B_EN]); // R2
   AST_BUSY_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rww_busy_o) |-> $past(erase_o || write_o)); // R3
   AST_BUSY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rww_busy_o) |-> $past(rww_reen_o || bufload_o)); // R4
   AST_EXPIRE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_ARMED) && last && !spm_exec_i) |=> !reg_rdata_o[B_EN]); // R6
   AST_SIG_BLOCKS_SPM: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_ARMED) && sig_q && spm_exec_i)
      |-> !(erase_o || write_o || lock_o || rww_reen_o || bufload_o)); // R7
   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({erase_o, write_o, lock_o, rww_reen_o, bufload_o})); // R9
   AST_OPER_HOLDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_OPER) && !flash_done_i) |=> reg_rdata_o[B_EN]); // R10
endmodule

// File: tb/flash_selfprog_ctrl_tb_top.sv
module flash_selfprog_ctrl_tb_top;
   localparam int AW   = 16;
   localparam int BOOT = 'h4C00;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_wr = 1'b0, spm = 1'b0, lpm = 1'b0, gie = 1'b0, done = 1'b0, fuse = 1'b1;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic erase, write, bufload, lock, reen, sigsel, busy, irq;
   logic [AW-1:0] rvec;
   int n_chk = 0, n_fail = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   flash_selfprog_ctrl #(.AW(AW), .BOOT_ADDR(BOOT)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
      .spm_exec_i(spm), .lpm_exec_i(lpm), .global_ie_i(gie), .flash_done_i(done),
      .boot_fuse_i(fuse), .erase_o(erase), .write_o(write), .bufload_o(bufload),
      .lock_o(lock), .rww_reen_o(reen), .sig_sel_o(sigsel), .rww_busy_o(busy),
      .ready_irq_o(irq), .reset_vec_o(rvec)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] d);
      @(negedge clk); reg_wr = 1'b1; wdata = d;
      @(negedge clk); reg_wr = 1'b0; wdata = 8'h00;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // store sampled at the next edge; returns the strobe vector seen in that cycle
   task automatic store(output logic [4:0] strobes);
      spm = 1'b1; #1;
      strobes = {erase, write, lock, reen, bufload};
      @(negedge clk); spm = 1'b0;
   endtask

   task automatic flash_finish();
      done = 1'b1; @(negedge clk); done = 1'b0;
   endtask

   initial begin
      #(20 * 200000);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [4:0] s;
      idle(2); rst_n = 1'b1; idle(1);
      // R1 reset value
      chk(rdata == 8'h00, "R1 reset", rdata, 0);
      chk(irq == 1'b0, "R2 reset irq", irq, 0);
      // R8 reset vector
      for (int f = 0; f < 2; f++) begin
         fuse = f[0]; #1;
         chk(rvec == (f == 0 ? AW'(BOOT) : '0), "R8 vector", rvec, (f == 0 ? BOOT : 0));
      end
      // R1 busy bit not writable
      wr(8'h40);
      chk(rdata == 8'h00, "R1 busy read-only", rdata, 0);

      // R6 R3 R10 R4 erase window sweep
      for (int n = 0; n < 6; n++) begin
         wr(8'h03);
         idle(n);
         store(s);
         chk(s == ((n <= 3) ? 5'b10000 : 5'b00000), "R6 erase window", s, n);
         if (n <= 3) begin
            chk(rdata == 8'h43 && busy, "R3/R10 busy during erase", rdata, 8'h43);
            idle(2);
            chk(rdata == 8'h43, "R10 enable held", rdata, 8'h43);
            flash_finish();
            chk(rdata == 8'h40, "R10 done clears enable", rdata, 8'h40);
            wr(8'h11);
            store(s);
            chk(s == 5'b00010, "R4 re-enable strobe", s, 5'b00010);
            chk(rdata == 8'h00 && !busy, "R4 busy cleared", rdata, 0);
         end else begin
            chk(rdata == 8'h00, "R6 expiry clears", rdata, 0);
         end
      end

      // R3 page write, then R5 buffer load clears busy
      wr(8'h05);
      idle(2);
      store(s);
      chk(s == 5'b01000, "R3 write strobe", s, 5'b01000);
      flash_finish();
      chk(rdata == 8'h40, "R3 busy after write", rdata, 8'h40);
      wr(8'h01);
      idle(1);
      store(s);
      chk(s == 5'b00001, "R5 load strobe", s, 5'b00001);
      chk(rdata == 8'h00, "R5 busy cleared", rdata, 0);

      // R12 lock bit
      wr(8'h09);
      store(s);
      chk(s == 5'b00100, "R12 lock strobe", s, 5'b00100);
      chk(rdata == 8'h00, "R12 lock clears", rdata, 0);

      // R7 signature window sweep
      for (int n = 0; n < 5; n++) begin
         wr(8'h21);
         idle(n);
         lpm = 1'b1; #1;
         chk(sigsel == (n <= 2), "R7 signature window", sigsel, (n <= 2));
         @(negedge clk); lpm = 1'b0;
         idle(5);
         chk(rdata == 8'h00, "R7 sig expiry", rdata, 0);
      end
      wr(8'h21);
      idle(1);
      store(s);
      chk(s == 5'b00000 && rdata == 8'h21, "R7 store blocked", rdata, 8'h21);
      idle(5);

      // R9 multi-command writes ignored
      wr(8'h80);
      for (int m = 0; m < 16; m++) begin
         if ($countones(m[3:0]) >= 2) begin
            wr({2'b00, m[3], 1'b0, m[2], m[1], m[0], 1'b1});
            chk(rdata == 8'h80, "R9 write ignored", rdata, 8'h80);
            store(s);
            chk(s == 5'b00000, "R9 nothing armed", s, 0);
         end
      end

      // R2 interrupt gating
      gie = 1'b0; #1;
      chk(irq == 1'b0, "R2 gie off", irq, 0);
      gie = 1'b1; #1;
      chk(irq == 1'b1, "R2 level on", irq, 1);
      wr(8'h83);
      chk(irq == 1'b0, "R2 armed no irq", irq, 0);
      // R11 write while armed changes only bit 7
      wr(8'h7F);
      chk(rdata == 8'h03, "R11 armed write", rdata, 8'h03);
      wr(8'h83);
      store(s);
      chk(s == 5'b00000, "R6 window closed by late store", s, 0);
      wr(8'h83);
      store(s);
      wr(8'h04);
      chk(rdata == 8'h43, "R11 write during erase", rdata, 8'h43);
      wr(8'h80);
      chk(irq == 1'b0, "R2 busy op no irq", irq, 0);
      flash_finish();
      chk(irq == 1'b1 && rdata == 8'hC0, "R2 irq after done", rdata, 8'hC0);
      gie = 1'b0; #1;
      chk(irq == 1'b0, "R2 gie removed", irq, 0);

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule